// File: doc/BRIEF.md
# Four-by-four interconnect switch with per-target round-robin ownership

This block joins four initiators to four targets. Every initiator presents one beat at a time: a valid flag, a 32-bit address, a write flag, 64 bits of write data and an end-of-transaction flag. It receives a ready flag and 64 bits of read data in return. The two most significant address bits pick the target, so each target owns one fixed quarter of the address space.

Each target has its own arbiter, so initiators that address different targets run in the same cycle. When two or more initiators want one target, one of them becomes its owner. The others see ready held low and must hold their request steady. The owner keeps the target until a beat carrying the end flag is accepted, and only then does that target arbitrate again. Contenders have equal standing. The search for the next owner starts at the initiator just after the previous winner of that target. A grant made on a free target takes effect in the same cycle as the request.

Top module: `xbar_fabric`

## Requirements
- R1: The target of a request is addr[31:30]: value 0 selects target 0, value 3 selects target 3.
- R2: A target's outgoing valid, address, write, write data and end flag equal those of its owning initiator. With no owner, all of them are zero.
- R3: Initiators that address different targets are all served in the same cycle.
- R4: No target has more than one owner at a time. A requester that does not own its target sees m_ready low.
- R5: Ownership lasts until the owner's beat with m_last high is accepted (target ready high). Other requesters stay stalled until then, even while the target holds ready low.
- R6: When a free target has several requesters, the winner is the first requester found by searching upward, with wraparound, from the initiator after the last one granted that target.
- R7: After reset every target counts initiator 3 as its last winner, so initiator 0 wins the first contest.
- R8: Read data and ready reach only the owning initiator. All other initiators see m_rdata zero.
- R9: A request to a free target is granted in the same cycle, so a beat with target ready high completes in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_valid | input | 4 | Per-initiator beat valid |
| m_addr | input | 4x32 | Per-initiator address |
| m_write | input | 4 | Per-initiator write flag |
| m_wdata | input | 4x64 | Per-initiator write data |
| m_last | input | 4 | Per-initiator end-of-transaction flag |
| m_ready | output | 4 | Beat accepted for this initiator |
| m_rdata | output | 4x64 | Read data returned to this initiator |
| s_valid | output | 4 | Per-target beat valid |
| s_addr | output | 4x32 | Per-target address from owner |
| s_write | output | 4 | Per-target write flag from owner |
| s_wdata | output | 4x64 | Per-target write data from owner |
| s_last | output | 4 | Per-target end flag from owner |
| s_ready | input | 4 | Per-target beat accept |
| s_rdata | input | 4x64 | Per-target read data |

## Verification
A wrong last-winner pointer is invisible until the next contest on that target. At that contest the wrong initiator's m_ready rises in the same cycle, so the table walks repeated contests on one target. A lost or stuck ownership flag shows in the first cycle after an unfinished beat: an initiator that should stall gets ready, or the owner loses the target. Routing faults show at once as wrong target-side fields or as read data leaking to an initiator that does not own the target.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int XB_MASTERS = 4;
  localparam int XB_SLAVES  = 4;
  localparam int XB_AW      = 32;
  localparam int XB_DW      = 64;
endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
  parameter int AW = 32,
  parameter int NS = 4
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  output logic [NS-1:0] req_oh
);
  localparam int SW = (NS > 1) ? $clog2(NS) : 1;

  function automatic logic [NS-1:0] target_of(input logic [AW-1:0] a);
    logic [NS-1:0] oh;
    oh = '0;
    oh[a[AW-1 -: SW]] = 1'b1;
    return oh;
  endfunction

  assign req_oh = valid ? target_of(addr) : '0;
endmodule

// File: rtl/xbar_slave_arb.sv
module xbar_slave_arb #(
  parameter int NM = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req,
  input  logic          beat_done,
  output logic [NM-1:0] grant
);
  localparam int IDW = (NM > 1) ? $clog2(NM) : 1;

  // first requester above 'last', wrapping
  function automatic logic [NM-1:0] rr_pick(input logic [NM-1:0] r,
                                            input logic [IDW-1:0] last);
    logic [NM-1:0] g;
    logic found;
    g = '0;
    found = 1'b0;
    for (int k = 1; k <= NM; k++) begin
      int idx;
      idx = (int'(last) + k) % NM;
      if (!found && r[idx]) begin
        g[idx] = 1'b1;
        found = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic logic [IDW-1:0] oh_to_id(input logic [NM-1:0] oh);
    logic [IDW-1:0] id;
    id = '0;
    for (int k = 0; k < NM; k++)
      if (oh[k]) id = IDW'(k);
    return id;
  endfunction

  logic          held_q;
  logic [NM-1:0] own_q;
  logic [IDW-1:0] last_q;
  logic [NM-1:0] pick;
  logic          new_win;

  assign pick    = rr_pick(req, last_q);
  assign grant   = held_q ? own_q : pick;
  assign new_win = !held_q && (|pick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      own_q  <= '0;
      last_q <= IDW'(NM - 1);
    end else if (new_win) begin
      last_q <= oh_to_id(pick);
      if (!beat_done) begin
        held_q <= 1'b1;
        own_q  <= pick;
      end
    end else if (held_q && beat_done) begin
      held_q <= 1'b0;
      own_q  <= '0;
    end
  end

  p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_hold_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && !beat_done) |=> (grant == $past(grant)));

  p_free_grant_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_q) |-> ((grant & ~req) == '0));

  p_no_idle_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_q && (|req)) |-> (|grant));
endmodule

// File: rtl/xbar_fabric.sv
module xbar_fabric
  import xbar_pkg::*;
#(
  parameter int NM = XB_MASTERS,
  parameter int NS = XB_SLAVES,
  parameter int AW = XB_AW,
  parameter int DW = XB_DW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NM-1:0]          m_valid,
  input  logic [NM-1:0][AW-1:0]  m_addr,
  input  logic [NM-1:0]          m_write,
  input  logic [NM-1:0][DW-1:0]  m_wdata,
  input  logic [NM-1:0]          m_last,
  output logic [NM-1:0]          m_ready,
  output logic [NM-1:0][DW-1:0]  m_rdata,
  output logic [NS-1:0]          s_valid,
  output logic [NS-1:0][AW-1:0]  s_addr,
  output logic [NS-1:0]          s_write,
  output logic [NS-1:0][DW-1:0]  s_wdata,
  output logic [NS-1:0]          s_last,
  input  logic [NS-1:0]          s_ready,
  input  logic [NS-1:0][DW-1:0]  s_rdata
);
  localparam int SW = (NS > 1) ? $clog2(NS) : 1;

  logic [NM-1:0][NS-1:0] req_ms;
  logic [NS-1:0][NM-1:0] req_sm;
  logic [NS-1:0][NM-1:0] gnt_sm;
  logic [NS-1:0]         beat_done;
  logic [NM-1:0]         owns_any;

  for (genvar m = 0; m < NM; m++) begin : g_dec
    xbar_decode #(.AW(AW), .NS(NS)) u_dec (
      .valid (m_valid[m]),
      .addr  (m_addr[m]),
      .req_oh(req_ms[m])
    );
  end

  always_comb begin
    for (int s = 0; s < NS; s++)
      for (int m = 0; m < NM; m++)
        req_sm[s][m] = req_ms[m][s];
  end

  for (genvar s = 0; s < NS; s++) begin : g_arb
    xbar_slave_arb #(.NM(NM)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_sm[s]),
      .beat_done(beat_done[s]),
      .grant    (gnt_sm[s])
    );
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      s_valid[s] = 1'b0;
      s_addr[s]  = '0;
      s_write[s] = 1'b0;
      s_wdata[s] = '0;
      s_last[s]  = 1'b0;
      for (int m = 0; m < NM; m++) begin
        if (gnt_sm[s][m]) begin
          s_valid[s] = s_valid[s] | m_valid[m];
          s_addr[s]  = s_addr[s]  | m_addr[m];
          s_write[s] = s_write[s] | m_write[m];
          s_wdata[s] = s_wdata[s] | m_wdata[m];
          s_last[s]  = s_last[s]  | m_last[m];
        end
      end
      beat_done[s] = s_valid[s] & s_ready[s] & s_last[s];
    end
  end

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      m_ready[m]  = 1'b0;
      m_rdata[m]  = '0;
      owns_any[m] = 1'b0;
      for (int s = 0; s < NS; s++) begin
        if (gnt_sm[s][m]) begin
          owns_any[m] = 1'b1;
          m_ready[m]  = m_ready[m] | s_ready[s];
          m_rdata[m]  = m_rdata[m] | s_rdata[s];
        end
      end
    end
  end

  for (genvar m = 0; m < NM; m++) begin : g_mchk
    p_ready_only_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
      m_ready[m] |-> owns_any[m]);
    p_stall_nonowner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid[m] && !owns_any[m]) |-> !m_ready[m]);
  end

  for (genvar s = 0; s < NS; s++) begin : g_schk
    p_decode_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid[s] |-> (s_addr[s][AW-1 -: SW] == SW'(s)));
  end
endmodule

// File: tb/test_xbar_fabric.sv
`timescale 1ns/1ps
module test_xbar_fabric;
  localparam int NM = 4;
  localparam int NS = 4;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int NV = 15;

  // {valid[3:0], sel m3..m0 (2b each), last[3:0], s_ready[3:0], expected m_ready[3:0]}
  localparam logic [23:0] VECS [NV] = '{
    {4'b0011, 8'h00, 4'b0011, 4'b0001, 4'b0001},  // R7 m0 wins first
    {4'b0011, 8'h00, 4'b0011, 4'b0001, 4'b0010},  // R6 rotate to m1
    {4'b1011, 8'h00, 4'b1011, 4'b0001, 4'b1000},  // R6 skip idle m2
    {4'b0011, 8'h00, 4'b0010, 4'b0001, 4'b0001},  // R5 m0 starts multi-beat
    {4'b0011, 8'h00, 4'b0010, 4'b0001, 4'b0001},  // R5 still m0
    {4'b0011, 8'h00, 4'b0011, 4'b0000, 4'b0000},  // R5 target not ready
    {4'b0011, 8'h00, 4'b0011, 4'b0001, 4'b0001},  // R5 m0 ends
    {4'b0011, 8'h00, 4'b0011, 4'b0001, 4'b0010},  // R6 m1 next
    {4'b1111, 8'he4, 4'b1111, 4'b1111, 4'b1111},  // R3 all parallel
    {4'b1100, 8'hf0, 4'b1100, 4'b1000, 4'b0100},  // R6 s3 after m3 -> m2
    {4'b1100, 8'hf0, 4'b1100, 4'b1000, 4'b1000},  // R6 then m3
    {4'b0011, 8'h09, 4'b0011, 4'b0100, 4'b0010},  // R4 m0 holds s1 unready
    {4'b0011, 8'h05, 4'b0011, 4'b0010, 4'b0001},  // R5 owner m0 keeps s1
    {4'b0010, 8'h05, 4'b0010, 4'b0010, 4'b0010},  // R9 m1 same cycle
    {4'b0000, 8'h00, 4'b0000, 4'b1111, 4'b0000}   // R4 idle
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NM-1:0]         m_valid;
  logic [NM-1:0][AW-1:0] m_addr;
  logic [NM-1:0]         m_write;
  logic [NM-1:0][DW-1:0] m_wdata;
  logic [NM-1:0]         m_last;
  logic [NM-1:0]         m_ready;
  logic [NM-1:0][DW-1:0] m_rdata;
  logic [NS-1:0]         s_valid;
  logic [NS-1:0][AW-1:0] s_addr;
  logic [NS-1:0]         s_write;
  logic [NS-1:0][DW-1:0] s_wdata;
  logic [NS-1:0]         s_last;
  logic [NS-1:0]         s_ready;
  logic [NS-1:0][DW-1:0] s_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xbar_fabric i_xbar_fabric (
    .clk(clk), .rst_n(rst_n),
    .m_valid(m_valid), .m_addr(m_addr), .m_write(m_write), .m_wdata(m_wdata),
    .m_last(m_last), .m_ready(m_ready), .m_rdata(m_rdata),
    .s_valid(s_valid), .s_addr(s_addr), .s_write(s_write), .s_wdata(s_wdata),
    .s_last(s_last), .s_ready(s_ready), .s_rdata(s_rdata)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    m_valid = '0; m_addr = '0; m_write = '0; m_wdata = '0; m_last = '0;
    s_ready = '0; s_rdata = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000ns;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    check(s_valid == '0, "R2 reset s_valid", 64'(s_valid), 64'h0);
    check(m_ready == '0, "R4 reset m_ready", 64'(m_ready), 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      @(negedge clk);
      v = VECS[i];
      m_valid = v[23:20];
      for (int m = 0; m < NM; m++) begin
        m_addr[m]  = {v[12 + 2*m +: 2], 30'(m * 256 + i)};
        m_wdata[m] = 64'(i * 16 + m);
      end
      m_last  = v[11:8];
      s_ready = v[7:4];
      #1;
      check(m_ready == v[3:0], $sformatf("R6/R5/R4 vector %0d m_ready", i),
            64'(m_ready), 64'(v[3:0]));
    end

    // routing: m2 writes to target 1, read data back only to m2
    @(negedge clk);
    idle_inputs();
    m_valid[2] = 1'b1;
    m_addr[2]  = {2'd1, 30'h0ABCDEF};
    m_write[2] = 1'b1;
    m_wdata[2] = 64'hA5A5_0F0F_1234_5678;
    m_last[2]  = 1'b1;
    s_ready[1] = 1'b1;
    s_rdata[1] = 64'hDEAD_BEEF_0000_0042;
    s_rdata[0] = 64'h1111;
    #1;
    check(s_valid == 4'b0010, "R1 target select", 64'(s_valid), 64'h2);
    check(s_addr[1] == {2'd1, 30'h0ABCDEF}, "R2 s_addr", 64'(s_addr[1]),
          64'({2'd1, 30'h0ABCDEF}));
    check(s_wdata[1] == 64'hA5A5_0F0F_1234_5678, "R2 s_wdata", s_wdata[1],
          64'hA5A5_0F0F_1234_5678);
    check(s_write[1] && s_last[1], "R2 s_write/s_last",
          64'({s_write[1], s_last[1]}), 64'h3);
    check(s_addr[0] == '0 && s_wdata[0] == '0, "R2 idle target zero",
          64'(s_addr[0]), 64'h0);
    check(m_rdata[2] == 64'hDEAD_BEEF_0000_0042, "R8 rdata to owner",
          m_rdata[2], 64'hDEAD_BEEF_0000_0042);
    check(m_rdata[0] == '0 && m_rdata[1] == '0, "R8 rdata blocked",
          m_rdata[0] | m_rdata[1], 64'h0);
    check(m_ready == 4'b0100, "R9 same-cycle grant", 64'(m_ready), 64'h4);

    // R7: after fresh reset, m0 beats m3 on target 2
    @(negedge clk);
    do_reset();
    m_valid    = 4'b1001;
    m_addr[0]  = {2'd2, 30'h10};
    m_addr[3]  = {2'd2, 30'h30};
    m_last     = 4'b1001;
    s_ready[2] = 1'b1;
    #1;
    check(m_ready == 4'b0001, "R7 m0 first after reset", 64'(m_ready), 64'h1);
    check(s_addr[2] == {2'd2, 30'h10}, "R7 s_addr from m0", 64'(s_addr[2]),
          64'({2'd2, 30'h10}));
    @(negedge clk);
    #1;
    check(m_ready == 4'b1000, "R6 m3 next", 64'(m_ready), 64'h8);

    @(negedge clk);
    idle_inputs();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule